// File: doc/BRIEF.md
# DDS Serial Command Decoder

This block is the control front end of a direct digital synthesizer that holds two frequency tuning words and four phase offsets. A host sends 16-bit command words over a four-wire serial link (clock idles high, data sampled on the rising clock edge, most significant bit first, one word per active-low select window). Each word is decoded into a command, a register address and a data byte, and the result is applied to a bank of registers that feed the synthesis core in parallel.

Wide values arrive in pieces. A byte-staging command only parks a byte in a one-byte holding register; a pair-commit command then writes the parked byte and its own byte together into one half of a tuning word, or into a whole phase offset, in a single clock cycle. Control commands pick the active frequency and phase registers and set the sync, source-select, sleep, core-reset and clear flags; for the last two groups the flag bits overlap the lower half of the command field.

The serial inputs are synchronised into the system clock domain, so the serial clock must run well below the system clock (at least four system clocks per serial half period).

Top module: `dds_cmd_decoder`

## Requirements
- R1: A word is shifted in MSB first on rising `sclk` edges while `cs_n` is low and is executed when `cs_n` rises; its effect appears at the outputs on the third rising `clk` edge after `cs_n` goes high.
- R2: A select window holding any number of `sclk` rising edges other than 16 (for example 15 or 17) is discarded and changes no output.
- R3: Codes 0x3 and 0x1 in bits [15:12] load bits [7:0] into the staging byte and change no output.
- R4: Code 0x2 with address bits [11:8] in 0x0–0x7 writes {staging byte, data byte} into frequency register addr[2], upper half (bits 31:16) when addr[1] is 1, lower half otherwise; with an address of 0x8 or above it changes nothing.
- R5: Code 0x0 with address 0x8–0xF writes {staging bits [3:0], data byte} into phase register addr[2:1]; with an address below 0x8 it changes nothing.
- R6: Code 0x6 sets `freq_sel_o` from bit 11 and `phase_sel_o` from bits [10:9].
- R7: A word with bits [15:14] = 2'b10 sets `sync_o` from bit 13 and `selsrc_o` from bit 12.
- R8: A word with bits [15:14] = 2'b11 sets `sleep_o`, `core_reset_o` and `clr_o` from bits 13, 12 and 11.
- R9: Codes 0x4, 0x5 and 0x7 change no output.
- R10: After reset `sleep_o`, `core_reset_o` and `clr_o` are 1; every tuning register, both selects, `sync_o` and `selsrc_o` are 0.
- R11: A pair-commit does not consume the staging byte: successive commits reuse it until the next byte-staging command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low word select |
| mosi | input | 1 | Serial data in |
| freq0_o | output | 32 | Frequency tuning word 0 |
| freq1_o | output | 32 | Frequency tuning word 1 |
| phase_o | output | 4x12 | Phase offsets, element i is register i |
| freq_sel_o | output | 1 | Active frequency register |
| phase_sel_o | output | 2 | Active phase register |
| sync_o | output | 1 | Sync flag |
| selsrc_o | output | 1 | Select-source flag |
| sleep_o | output | 1 | Sleep flag |
| core_reset_o | output | 1 | Synthesis core reset flag |
| clr_o | output | 1 | Clear flag |

## Verification
The hardest situation to reach is a commit whose staging byte was written several words earlier, with malformed windows and ignored codes in between that must not disturb it. The stimulus stages one byte, sends 15- and 17-edge windows and unknown codes, then issues two commits in a row to different halves, so the staging byte's survival shows directly in the tuning word. A behavioural model updated three clocks after each select release is compared with every output on every clock, which also pins down the commit latency.

// File: rtl/dds_cmd_pkg.sv
package dds_cmd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int FREQ_BITS  = 32;
  localparam int PHASE_BITS = 12;
  localparam int N_FREQ     = 2;
  localparam int N_PHASE    = 4;
  localparam int BYTE_BITS  = 8;
  localparam int HALF_BITS  = FREQ_BITS / 2;

  typedef enum logic [3:0] {
    OP_PHASE_PAIR = 4'h0,
    OP_PHASE_BYTE = 4'h1,
    OP_FREQ_PAIR  = 4'h2,
    OP_FREQ_BYTE  = 4'h3,
    OP_SELECT     = 4'h6
  } op_e;

  typedef struct packed {
    logic [3:0]           op;
    logic [3:0]           addr;
    logic [BYTE_BITS-1:0] data;
  } frame_t;

  // Replace one half of a tuning word with {hi, lo}.
  function automatic logic [FREQ_BITS-1:0] merge_half(
      input logic [FREQ_BITS-1:0] old_word,
      input logic                 upper,
      input logic [BYTE_BITS-1:0] hi,
      input logic [BYTE_BITS-1:0] lo);
    logic [FREQ_BITS-1:0] r;
    r = old_word;
    if (upper) r[FREQ_BITS-1:HALF_BITS] = {hi, lo};
    else       r[HALF_BITS-1:0]         = {hi, lo};
    return r;
  endfunction

  // Phase offset from the staging byte's low bits and the data byte.
  function automatic logic [PHASE_BITS-1:0] join_phase(
      input logic [BYTE_BITS-1:0] hi,
      input logic [BYTE_BITS-1:0] lo);
    logic [2*BYTE_BITS-1:0] w;
    w = {hi, lo};
    return w[PHASE_BITS-1:0];
  endfunction
endpackage

// File: rtl/dds_spi_rx.sv
module dds_spi_rx #(
  parameter int SYNC_STAGES = 2,
  parameter int FRAME_BITS  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk,
  input  logic                  cs_n,
  input  logic                  mosi,
  output logic                  frame_valid_o,
  output logic [FRAME_BITS-1:0] frame_o
);
  localparam int CNT_W   = $clog2(FRAME_BITS + 2);
  localparam int CNT_SAT = FRAME_BITS + 1;

  logic [SYNC_STAGES-1:0] sclk_pipe, cs_pipe, mosi_pipe;
  logic sclk_d, cs_d;
  logic sclk_s, cs_s, mosi_s;
  logic sclk_rise, cs_fall, cs_rise;
  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_pipe <= '1;
      cs_pipe   <= '1;
      mosi_pipe <= '0;
      sclk_d    <= 1'b1;
      cs_d      <= 1'b1;
    end else begin
      sclk_pipe <= {sclk_pipe[SYNC_STAGES-2:0], sclk};
      cs_pipe   <= {cs_pipe[SYNC_STAGES-2:0], cs_n};
      mosi_pipe <= {mosi_pipe[SYNC_STAGES-2:0], mosi};
      sclk_d    <= sclk_s;
      cs_d      <= cs_s;
    end
  end

  assign sclk_s    = sclk_pipe[SYNC_STAGES-1];
  assign cs_s      = cs_pipe[SYNC_STAGES-1];
  assign mosi_s    = mosi_pipe[SYNC_STAGES-1];
  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_fall   = ~cs_s & cs_d;
  assign cs_rise   = cs_s & ~cs_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
    end else if (cs_fall) begin
      bit_cnt <= '0;
    end else if (!cs_s && sclk_rise) begin
      shreg <= {shreg[FRAME_BITS-2:0], mosi_s};
      if (bit_cnt != CNT_W'(CNT_SAT)) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_valid_o = cs_rise && (bit_cnt == CNT_W'(FRAME_BITS));
  assign frame_o       = shreg;
endmodule

// File: rtl/dds_cmd_exec.sv
module dds_cmd_exec
  import dds_cmd_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               frame_valid_i,
  input  logic [FRAME_BITS-1:0]              frame_i,
  output logic [FREQ_BITS-1:0]               freq0_o,
  output logic [FREQ_BITS-1:0]               freq1_o,
  output logic [N_PHASE-1:0][PHASE_BITS-1:0] phase_o,
  output logic                               freq_sel_o,
  output logic [1:0]                         phase_sel_o,
  output logic                               sync_o,
  output logic                               selsrc_o,
  output logic                               sleep_o,
  output logic                               core_reset_o,
  output logic                               clr_o
);
  frame_t f;
  logic ev_stage, ev_freq, ev_phase, ev_select, ev_sync, ev_ctrl;
  logic [BYTE_BITS-1:0]  stage_q;
  logic [FREQ_BITS-1:0]  freq_q  [N_FREQ];
  logic [PHASE_BITS-1:0] phase_q [N_PHASE];

  assign f = frame_t'(frame_i);

  // Command events; the two flag groups are recognised by the top two bits.
  always_comb begin
    ev_stage  = 1'b0;
    ev_freq   = 1'b0;
    ev_phase  = 1'b0;
    ev_select = 1'b0;
    ev_sync   = 1'b0;
    ev_ctrl   = 1'b0;
    if (frame_valid_i) begin
      if (f.op[3:2] == 2'b11)      ev_ctrl = 1'b1;
      else if (f.op[3:2] == 2'b10) ev_sync = 1'b1;
      else begin
        unique case (f.op)
          OP_FREQ_BYTE, OP_PHASE_BYTE: ev_stage = 1'b1;
          OP_FREQ_PAIR:  ev_freq  = ~f.addr[3];
          OP_PHASE_PAIR: ev_phase = f.addr[3];
          OP_SELECT:     ev_select = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (ev_stage) stage_q <= f.data;
  end

  for (genvar g = 0; g < N_FREQ; g++) begin : g_freq
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        freq_q[g] <= '0;
      else if (ev_freq && (f.addr[2] == 1'(g)))
        freq_q[g] <= merge_half(freq_q[g], f.addr[1], stage_q, f.data);
    end
  end

  for (genvar p = 0; p < N_PHASE; p++) begin : g_phase
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        phase_q[p] <= '0;
      else if (ev_phase && (f.addr[2:1] == 2'(p)))
        phase_q[p] <= join_phase(stage_q, f.data);
    end
    assign phase_o[p] = phase_q[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_sel_o   <= 1'b0;
      phase_sel_o  <= 2'b00;
      sync_o       <= 1'b0;
      selsrc_o     <= 1'b0;
      sleep_o      <= 1'b1;
      core_reset_o <= 1'b1;
      clr_o        <= 1'b1;
    end else begin
      if (ev_select) begin
        freq_sel_o  <= f.addr[3];
        phase_sel_o <= f.addr[2:1];
      end
      if (ev_sync) begin
        sync_o   <= f.op[1];
        selsrc_o <= f.op[0];
      end
      if (ev_ctrl) begin
        sleep_o      <= f.op[1];
        core_reset_o <= f.op[0];
        clr_o        <= f.addr[3];
      end
    end
  end

  assign freq0_o = freq_q[0];
  assign freq1_o = freq_q[1];
endmodule

// File: rtl/dds_cmd_decoder.sv
module dds_cmd_decoder
  import dds_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               sclk,
  input  logic                               cs_n,
  input  logic                               mosi,
  output logic [FREQ_BITS-1:0]               freq0_o,
  output logic [FREQ_BITS-1:0]               freq1_o,
  output logic [N_PHASE-1:0][PHASE_BITS-1:0] phase_o,
  output logic                               freq_sel_o,
  output logic [1:0]                         phase_sel_o,
  output logic                               sync_o,
  output logic                               selsrc_o,
  output logic                               sleep_o,
  output logic                               core_reset_o,
  output logic                               clr_o
);
  logic                  frame_valid;
  logic [FRAME_BITS-1:0] frame_word;

  dds_spi_rx #(
    .SYNC_STAGES(SYNC_STAGES),
    .FRAME_BITS (FRAME_BITS)
  ) u_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .sclk         (sclk),
    .cs_n         (cs_n),
    .mosi         (mosi),
    .frame_valid_o(frame_valid),
    .frame_o      (frame_word)
  );

  dds_cmd_exec u_exec (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_valid_i(frame_valid),
    .frame_i      (frame_word),
    .freq0_o      (freq0_o),
    .freq1_o      (freq1_o),
    .phase_o      (phase_o),
    .freq_sel_o   (freq_sel_o),
    .phase_sel_o  (phase_sel_o),
    .sync_o       (sync_o),
    .selsrc_o     (selsrc_o),
    .sleep_o      (sleep_o),
    .core_reset_o (core_reset_o),
    .clr_o        (clr_o)
  );
endmodule

// File: rtl/dds_cmd_checker.sv
module dds_cmd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        frame_valid,
  input logic [15:9] hdr,
  input logic [31:0] freq0,
  input logic [31:0] freq1,
  input logic [47:0] phase,
  input logic        freq_sel,
  input logic [1:0]  phase_sel,
  input logic        sync,
  input logic        selsrc,
  input logic        sleep,
  input logic        core_reset,
  input logic        clr
);
  logic [31:0] ctrl_bits;
  assign ctrl_bits = {23'd0, freq_sel, phase_sel, sync, selsrc, sleep, core_reset, clr};

  AST_IDLE_TUNE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> ($stable(freq0) && $stable(freq1) && $stable(phase))); // R1

  AST_IDLE_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |=> $stable(ctrl_bits)); // R2

  AST_STAGE_NO_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && (hdr[15:12] == 4'h3 || hdr[15:12] == 4'h1))
      |=> ($stable(freq0) && $stable(freq1) && $stable(phase) && $stable(ctrl_bits))); // R3

  AST_SELECT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && hdr[15:12] == 4'h6)
      |=> (freq_sel == $past(hdr[11]) && phase_sel == $past(hdr[10:9]))); // R6

  AST_SYNC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && hdr[15:14] == 2'b10)
      |=> (sync == $past(hdr[13]) && selsrc == $past(hdr[12]))); // R7

  AST_POWER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && hdr[15:14] == 2'b11)
      |=> ({sleep, core_reset, clr} == $past(hdr[13:11]))); // R8

  AST_UNKNOWN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && (hdr[15:12] == 4'h4 || hdr[15:12] == 4'h5 || hdr[15:12] == 4'h7))
      |=> ($stable(freq0) && $stable(freq1) && $stable(phase) && $stable(ctrl_bits))); // R9
endmodule

bind dds_cmd_decoder dds_cmd_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_valid(frame_valid),
  .hdr        (frame_word[15:9]),
  .freq0      (freq0_o),
  .freq1      (freq1_o),
  .phase      (phase_o),
  .freq_sel   (freq_sel_o),
  .phase_sel  (phase_sel_o),
  .sync       (sync_o),
  .selsrc     (selsrc_o),
  .sleep      (sleep_o),
  .core_reset (core_reset_o),
  .clr        (clr_o)
);

// File: tb/dds_cmd_decoder_test.sv
`timescale 1ns/1ps
module dds_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic [31:0] freq0_o, freq1_o;
  logic [3:0][11:0] phase_o;
  logic freq_sel_o, sync_o, selsrc_o, sleep_o, core_reset_o, clr_o;
  logic [1:0] phase_sel_o;

  always #2.5 clk = ~clk;

  dds_cmd_decoder uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .freq0_o(freq0_o), .freq1_o(freq1_o), .phase_o(phase_o),
    .freq_sel_o(freq_sel_o), .phase_sel_o(phase_sel_o),
    .sync_o(sync_o), .selsrc_o(selsrc_o), .sleep_o(sleep_o),
    .core_reset_o(core_reset_o), .clr_o(clr_o)
  );

  // Behavioural reference state
  logic [31:0] m_freq [2];
  logic [11:0] m_phase [4];
  logic [7:0]  m_stage;
  logic        m_fsel, m_sync, m_selsrc, m_sleep, m_rst, m_clr;
  logic [1:0]  m_psel;

  int checks = 0;
  int errors = 0;
  bit compare_on = 0;
  bit done = 0;

  task automatic model_reset();
    m_freq[0] = 0; m_freq[1] = 0;
    for (int i = 0; i < 4; i++) m_phase[i] = 0;
    m_stage = 0; m_fsel = 0; m_psel = 0; m_sync = 0; m_selsrc = 0;
    m_sleep = 1; m_rst = 1; m_clr = 1;
  endtask

  task automatic model_apply(input logic [15:0] w);
    int op, a;
    logic [7:0] d;
    op = int'(w[15:12]);
    a  = int'(w[11:8]);
    d  = w[7:0];
    if (op >= 12) begin
      m_sleep = w[13]; m_rst = w[12]; m_clr = w[11];
    end else if (op >= 8) begin
      m_sync = w[13]; m_selsrc = w[12];
    end else if (op == 3 || op == 1) begin
      m_stage = d;
    end else if (op == 2) begin
      if (a < 8) m_freq[a / 4][((a % 4) / 2) * 16 +: 16] = {m_stage, d};
    end else if (op == 0) begin
      if (a >= 8) m_phase[(a - 8) / 2] = {m_stage[3:0], d};
    end else if (op == 6) begin
      m_fsel = w[11]; m_psel = w[10:9];
    end
  endtask

  task automatic fail_line(input string tag, input logic [31:0] act, input logic [31:0] exp);
    errors++;
    $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) fail_line(tag, act, exp);
  endtask

  // Every-clock comparison against the model
  always @(negedge clk) begin
    if (compare_on) begin
      logic bad;
      bad = 0;
      checks++;
      if (freq0_o !== m_freq[0]) begin fail_line("R4 freq0", freq0_o, m_freq[0]); bad = 1; end
      if (freq1_o !== m_freq[1]) begin fail_line("R4 freq1", freq1_o, m_freq[1]); bad = 1; end
      for (int i = 0; i < 4; i++)
        if (phase_o[i] !== m_phase[i]) begin
          fail_line("R5 phase", 32'(phase_o[i]), 32'(m_phase[i])); bad = 1;
        end
      if ({freq_sel_o, phase_sel_o} !== {m_fsel, m_psel})
        begin fail_line("R6 selects", 32'({freq_sel_o, phase_sel_o}), 32'({m_fsel, m_psel})); bad = 1; end
      if ({sync_o, selsrc_o} !== {m_sync, m_selsrc})
        begin fail_line("R7 sync/src", 32'({sync_o, selsrc_o}), 32'({m_sync, m_selsrc})); bad = 1; end
      if ({sleep_o, core_reset_o, clr_o} !== {m_sleep, m_rst, m_clr})
        begin fail_line("R8 power", 32'({sleep_o, core_reset_o, clr_o}), 32'({m_sleep, m_rst, m_clr})); bad = 1; end
      if (bad) errors--;
      if (bad) errors++;
    end
  end

  // Send one select window with nbits clock edges, MSB first (R1)
  task automatic send(input logic [15:0] w, input int nbits);
    logic [16:0] bits;
    bits = {w, 1'b0};
    if (nbits == 17) bits = {w, 1'b1};
    @(negedge clk); cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      mosi = (nbits == 17) ? bits[16 - i] : w[15 - i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    cs_n = 1'b1;
    repeat (3) @(posedge clk);
    if (nbits == 16) model_apply(w);
    repeat (4) @(negedge clk);
  endtask

  task automatic word(input logic [15:0] w);
    send(w, 16);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (4) @(negedge clk);
    // R10: reset state
    check("R10 sleep/reset/clr", 32'({sleep_o, core_reset_o, clr_o}), 32'h7);
    check("R10 freq0", freq0_o, 32'h0);
    check("R10 phase3", 32'(phase_o[3]), 32'h0);
    check("R10 selects", 32'({freq_sel_o, phase_sel_o, sync_o, selsrc_o}), 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    compare_on = 1;

    // R1 / R4: full frequency 0 load, MSB fragment first
    word(16'h3312); word(16'h2234); word(16'h3156); word(16'h2078);
    check("R1 R4 freq0 four-word load", freq0_o, 32'h12345678);

    // R3: stage alone changes nothing
    word(16'h37AB);
    check("R3 stage leaves freq0", freq0_o, 32'h12345678);
    check("R3 stage leaves freq1", freq1_o, 32'h0);

    // R2: short and long windows are discarded
    send(16'h6E00, 15);
    check("R2 15-edge window", 32'({freq_sel_o, phase_sel_o}), 32'h0);
    send(16'h6E00, 17);
    check("R2 17-edge window", 32'({freq_sel_o, phase_sel_o}), 32'h0);

    // R9: unknown codes ignored
    word(16'h4512); word(16'h5699); word(16'h7F00);
    check("R9 unknown codes freq0", freq0_o, 32'h12345678);
    check("R9 unknown codes ctrl", 32'({freq_sel_o, phase_sel_o, sync_o, selsrc_o}), 32'h0);

    // R11: staging byte AB survives the above and serves two commits
    word(16'h2611); word(16'h2422);
    check("R11 staging reused", freq1_o, 32'hAB11AB22);

    // R4: frequency commit to a phase address is ignored
    word(16'h2955);
    check("R4 freq commit at 0x9 ignored", 32'(phase_o[0]), 32'h0);

    // R5: phase 2 load, upper nibble of staging dropped
    word(16'h1DF7); word(16'h0C5A);
    check("R5 phase2", 32'(phase_o[2]), 32'h75A);
    word(16'h1F0C); word(16'h0E3D);
    check("R5 phase3", 32'(phase_o[3]), 32'hC3D);
    // R5: phase commit to a frequency address is ignored
    word(16'h0199);
    check("R5 phase commit at 0x1 ignored", freq0_o, 32'h12345678);

    // R6: selects
    word(16'h6E00);
    check("R6 select f1 p3", 32'({freq_sel_o, phase_sel_o}), 32'h7);
    word(16'h6200);
    check("R6 select f0 p1", 32'({freq_sel_o, phase_sel_o}), 32'h1);

    // R7: sync / select-source
    word(16'hB000);
    check("R7 sync+src", 32'({sync_o, selsrc_o}), 32'h3);
    word(16'h9000);
    check("R7 src only", 32'({sync_o, selsrc_o}), 32'h1);

    // R8: power flags
    word(16'hC000);
    check("R8 all clear", 32'({sleep_o, core_reset_o, clr_o}), 32'h0);
    word(16'hE800);
    check("R8 sleep+clr", 32'({sleep_o, core_reset_o, clr_o}), 32'h5);

    repeat (10) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule